// File: doc/BRIEF.md
# DRAM Power-Down State Tracker

This block is the controller's model of a DDR3 device's power state as it enters and leaves power-down. On each clock it samples the clock-enable level that the controller drives to the device, the command on the command bus, a vector of open banks, whether the DLL is locked, and the chosen exit speed for precharge power-down. A falling clock-enable in the awake state starts power-down. The bank vector at that edge picks the mode. Any open bank gives active power-down. With every bank closed the device goes into precharge power-down, with either a slow exit (DLL off) or a fast exit (DLL on).

The tracker times two windows. One follows entry, during which only NOP or deselect may be issued. The other follows exit and lasts as long as the mode requires. The tracker reports whether the DLL is running and whether the on-die termination must be handled as asynchronous. If the DLL was unlocked at entry, it demands a DLL reset after exit. Any command other than NOP or deselect issued where only those are allowed sets a sticky violation flag. All pins are plain control and status levels; the block carries no data stream and has no handshake.

Top module: `pd_state_tracker`

## Requirements
- R1: After reset, `pd_mode` is 0 (awake), `dll_on` is 1, and `entry_wait`, `exit_wait`, `dll_reset_req`, `odt_async` and `proto_err` are all 0.
- R2: A clock edge where `cke` is sampled 0, having been sampled 1 on the previous edge while awake, is an entry edge. If any bit of `bank_open` is 1 at that edge, `pd_mode` becomes 1 (active power-down) after the edge, and `dll_on` stays 1.
- R3: At an entry edge with `bank_open` all zero, `pd_mode` becomes 2 (precharge, slow exit) if `slow_exit_en` is 1, or 3 (precharge, fast exit) if it is 0. `dll_on` is 0 in mode 2 and 1 in mode 3.
- R4: `entry_wait` is 1 for exactly `TCPDED` cycles, starting with the cycle after the entry edge.
- R5: A clock edge where `cke` is sampled 1 while in power-down is an exit edge. After it `pd_mode` is 0 and `exit_wait` is 1 for exactly N cycles. N = max(`XPDLL_CK`, ceil(`XPDLL_PS`/`TCK_PS`)) when leaving mode 2, and `TXP` otherwise.
- R6: After a slow exit, `dll_on` returns to 1 one cycle after `exit_wait` falls.
- R7: If `dll_locked` was 0 at the entry edge, `dll_reset_req` becomes 1 after the exit edge. It clears after an edge where `cmd` is 7 (mode register set) while awake with `exit_wait` low. If `dll_locked` was 1 at entry, the flag is left unchanged.
- R8: `odt_async` is 1 while `pd_mode` is 2 and during the exit window that follows it, and 0 at all other times.
- R9: `cmd` encoding: 0 NOP, 1 deselect, 2 read, 3 write, 4 activate, 5 precharge, 6 refresh, 7 mode register set. A code other than 0 or 1 on an entry edge, in power-down, or while either window is open sets `proto_err`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level driven to the device |
| cmd | input | 3 | Command code issued this cycle (R9 encoding) |
| bank_open | input | NBANK | One bit per bank, 1 = row open |
| dll_locked | input | 1 | DLL currently locked |
| slow_exit_en | input | 1 | 1 = precharge power-down exits slowly with DLL off |
| pd_mode | output | 2 | 0 awake, 1 active, 2 precharge slow, 3 precharge fast |
| dll_on | output | 1 | DLL running |
| entry_wait | output | 1 | Post-entry quiet window open |
| exit_wait | output | 1 | Post-exit window open |
| dll_reset_req | output | 1 | DLL reset must precede reads |
| odt_async | output | 1 | Termination must be treated as asynchronous |
| proto_err | output | 1 | Sticky command-rule violation |

## Verification
The bench sweeps every bank pattern against both exit speeds and both DLL-lock states, and measures the length of each window. A design that ORed the bank vector wrongly would report precharge power-down with a bank still open. If it chose the exit length from the exit-speed bit instead of the mode, an active power-down would get the long slow-exit window. An off-by-one counter shows up directly as a wrong window length. A design that brought the DLL back inside the exit window, or kept `odt_async` high after it, would fail the checks made on the cycle right after the window. The bench also checks that a mode register set clears the reset request, and that a read inside the entry window latches `proto_err` until reset.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_DES = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3,
    CMD_ACT = 3'd4, CMD_PRE = 3'd5, CMD_REF = 3'd6, CMD_MRS = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PM_AWAKE = 2'd0, PM_ACTIVE = 2'd1, PM_PRE_SLOW = 2'd2, PM_PRE_FAST = 2'd3
  } pmode_e;

  function automatic logic is_quiet(input logic [2:0] c);
    return (c == CMD_NOP) || (c == CMD_DES);
  endfunction
endpackage

// File: rtl/pdt_win_timer.sv
module pdt_win_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pdt_mode_fsm.sv
module pdt_mode_fsm
  import pdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   entry_evt,
  input  logic   exit_evt,
  input  logic   any_open,
  input  logic   slow_exit_en,
  input  logic   dll_locked,
  input  logic   exit_busy,
  input  logic   mrs_clear,
  output pmode_e mode,
  output logic   dll_on,
  output logic   dll_reset_req,
  output logic   slow_exiting
);
  logic locked_at_entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode            <= PM_AWAKE;
      dll_on          <= 1'b1;
      dll_reset_req   <= 1'b0;
      slow_exiting    <= 1'b0;
      locked_at_entry <= 1'b1;
    end else begin
      if (entry_evt) begin
        locked_at_entry <= dll_locked;
        if (any_open)          mode <= PM_ACTIVE;
        else if (slow_exit_en) begin
          mode   <= PM_PRE_SLOW;
          dll_on <= 1'b0;
        end else               mode <= PM_PRE_FAST;
      end else if (exit_evt) begin
        mode         <= PM_AWAKE;
        slow_exiting <= (mode == PM_PRE_SLOW);
        if (!locked_at_entry) dll_reset_req <= 1'b1;
      end else begin
        if (slow_exiting && !exit_busy) begin
          slow_exiting <= 1'b0;
          dll_on       <= 1'b1;
        end
        if (mrs_clear) dll_reset_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdt_proto_mon.sv
module pdt_proto_mon
  import pdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restricted,
  input  logic [2:0] cmd,
  output logic       proto_err
);
  always_ff @(posedge clk) begin
    if (!rst_n)                              proto_err <= 1'b0;
    else if (restricted && !is_quiet(cmd))   proto_err <= 1'b1;
  end
endmodule

// File: rtl/pd_state_tracker.sv
module pd_state_tracker
  import pdt_pkg::*;
#(
  parameter int NBANK    = 8,
  parameter int TCK_PS   = 1250,
  parameter int XPDLL_CK = 10,
  parameter int XPDLL_PS = 24000,
  parameter int TXP      = 3,
  parameter int TCPDED   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [2:0]       cmd,
  input  logic [NBANK-1:0] bank_open,
  input  logic             dll_locked,
  input  logic             slow_exit_en,
  output logic [1:0]       pd_mode,
  output logic             dll_on,
  output logic             entry_wait,
  output logic             exit_wait,
  output logic             dll_reset_req,
  output logic             odt_async,
  output logic             proto_err
);
  localparam int PS_CYC   = (XPDLL_PS + TCK_PS - 1) / TCK_PS;
  localparam int SLOW_CYC = (PS_CYC > XPDLL_CK) ? PS_CYC : XPDLL_CK;
  localparam int MAXW     = (SLOW_CYC > TXP) ? SLOW_CYC : TXP;
  localparam int XW       = $clog2(MAXW + 1);
  localparam int EW       = $clog2(TCPDED + 1);

  pmode_e  mode;
  logic    cke_q;
  logic    entry_evt, exit_evt;
  logic    slow_exiting;
  logic [XW-1:0] exit_len;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  assign entry_evt = cke_q && !cke && (mode == PM_AWAKE);
  assign exit_evt  = cke && (mode != PM_AWAKE);
  assign exit_len  = (mode == PM_PRE_SLOW) ? XW'(SLOW_CYC) : XW'(TXP);

  pdt_win_timer #(.W(EW)) u_entry_win (
    .clk(clk), .rst_n(rst_n), .load(entry_evt),
    .load_val(EW'(TCPDED)), .busy(entry_wait)
  );

  pdt_win_timer #(.W(XW)) u_exit_win (
    .clk(clk), .rst_n(rst_n), .load(exit_evt),
    .load_val(exit_len), .busy(exit_wait)
  );

  pdt_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .entry_evt(entry_evt), .exit_evt(exit_evt),
    .any_open(|bank_open), .slow_exit_en(slow_exit_en),
    .dll_locked(dll_locked), .exit_busy(exit_wait),
    .mrs_clear((cmd == CMD_MRS) && (mode == PM_AWAKE) && !exit_wait),
    .mode(mode), .dll_on(dll_on), .dll_reset_req(dll_reset_req),
    .slow_exiting(slow_exiting)
  );

  pdt_proto_mon u_mon (
    .clk(clk), .rst_n(rst_n),
    .restricted(entry_evt || (mode != PM_AWAKE) || entry_wait || exit_wait),
    .cmd(cmd), .proto_err(proto_err)
  );

  assign pd_mode   = mode;
  assign odt_async = (mode == PM_PRE_SLOW) || (slow_exiting && exit_wait);
endmodule

// File: rtl/pd_state_tracker_chk.sv
module pd_state_tracker_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] bank_open,
  input logic             entry_evt,
  input logic [1:0]       pd_mode,
  input logic             dll_on,
  input logic             exit_wait,
  input logic             odt_async,
  input logic             proto_err
);
  // R2
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_evt && (|bank_open)) |=> (pd_mode == 2'd1 && dll_on));
  // R3
  slow_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'd2) |-> !dll_on);
  // R5
  exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode != 2'd0) |=> (pd_mode != 2'd0 || exit_wait));
  // R8
  odt_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odt_async |-> !dll_on);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind pd_state_tracker pd_state_tracker_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .entry_evt(entry_evt),
  .pd_mode(pd_mode), .dll_on(dll_on), .exit_wait(exit_wait),
  .odt_async(odt_async), .proto_err(proto_err)
);

// File: tb/pd_state_tracker_tb.sv
module pd_state_tracker_tb;
  localparam int NBANK    = 8;
  localparam int TCK_PS   = 1250;
  localparam int XPDLL_CK = 10;
  localparam int XPDLL_PS = 24000;
  localparam int TXP      = 3;
  localparam int TCPDED   = 4;
  localparam int PSC      = (XPDLL_PS + TCK_PS - 1) / TCK_PS;
  localparam int SLOWN    = (PSC > XPDLL_CK) ? PSC : XPDLL_CK;

  logic clk = 1'b0;
  logic rst_n;
  logic cke;
  logic [2:0] cmd;
  logic [NBANK-1:0] bank_open;
  logic dll_locked, slow_exit_en;
  logic [1:0] pd_mode;
  logic dll_on, entry_wait, exit_wait, dll_reset_req, odt_async, proto_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pd_state_tracker #(.NBANK(NBANK), .TCK_PS(TCK_PS), .XPDLL_CK(XPDLL_CK),
    .XPDLL_PS(XPDLL_PS), .TXP(TXP), .TCPDED(TCPDED)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank_open(bank_open),
    .dll_locked(dll_locked), .slow_exit_en(slow_exit_en), .pd_mode(pd_mode),
    .dll_on(dll_on), .entry_wait(entry_wait), .exit_wait(exit_wait),
    .dll_reset_req(dll_reset_req), .odt_async(odt_async), .proto_err(proto_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int em, ed, el;
    rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; bank_open = '0;
    dll_locked = 1'b1; slow_exit_en = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 mode", pd_mode, 0);
    chk("R1 dll_on", dll_on, 1);
    chk("R1 flags", {entry_wait, exit_wait, dll_reset_req, odt_async, proto_err}, 0);

    for (int b = 0; b < (1 << NBANK); b++) begin
      for (int s = 0; s < 2; s++) begin
        for (int l = 0; l < 2; l++) begin
          bank_open = NBANK'(b); slow_exit_en = s[0]; dll_locked = l[0];
          cke = 1'b1; cmd = 3'd0;
          cyc();
          cke = 1'b0;
          cyc();
          em = (b != 0) ? 1 : (s != 0 ? 2 : 3);
          ed = (em == 2) ? 0 : 1;
          el = (em == 2) ? SLOWN : TXP;
          // R2 / R3 mode and DLL after entry
          chk(b != 0 ? "R2 mode" : "R3 mode", pd_mode, em);
          chk(b != 0 ? "R2 dll_on" : "R3 dll_on", dll_on, ed);
          // R8
          chk("R8 odt in pd", odt_async, (em == 2) ? 1 : 0);
          // R4 entry window length
          n = 0;
          repeat (TCPDED + 3) begin
            if (entry_wait) n++;
            cyc();
          end
          chk("R4 entry window", n, TCPDED);
          cke = 1'b1;
          cyc();
          chk("R5 awake", pd_mode, 0);
          // R7 request after exit
          chk("R7 req set", dll_reset_req, l ? 0 : 1);
          n = 0;
          while (exit_wait && n < 64) begin
            n++;
            cyc();
          end
          // R5 exit window length
          chk("R5 exit window", n, el);
          chk("R8 odt after window", odt_async, 0);
          cyc();
          // R6 DLL back on
          chk("R6 dll_on", dll_on, 1);
          cmd = 3'd7;
          cyc();
          cmd = 3'd0;
          chk("R7 req cleared", dll_reset_req, 0);
          chk("R9 no err", proto_err, 0);
        end
      end
    end

    // R9: read inside the entry window latches the error until reset
    bank_open = '0; slow_exit_en = 1'b0; dll_locked = 1'b1; cke = 1'b1;
    cyc();
    cke = 1'b0;
    cyc();
    cmd = 3'd2;
    cyc();
    cmd = 3'd0;
    chk("R9 err set", proto_err, 1);
    cke = 1'b1;
    repeat (TXP + 4) cyc();
    chk("R9 err sticky", proto_err, 1);
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R9 err reset", proto_err, 0);

    // R7: mode register set inside the exit window does not clear the request
    dll_locked = 1'b0; cke = 1'b1;
    cyc();
    cke = 1'b0;
    repeat (TCPDED + 1) cyc();
    cke = 1'b1;
    cyc();
    cmd = 3'd7;
    cyc();
    cmd = 3'd0;
    chk("R7 req kept in window", dll_reset_req, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule